// File: doc/BRIEF.md
# ADC Serial Power-Management Controller

This block holds the power policy of a serial-interface analog-to-digital converter. It watches the chip-select, serial clock and serial data lines in the system-clock domain. From them it keeps a small control word: a two-bit power mode and a bit that turns the internal reference off. From the mode and the line edges it decides when the converter core and its internal reference get power.

A power-up request starts a timer. The timer runs in system clocks, and the ready output rises when it expires. The timer uses the long delay when the reference is also starting from cold. It uses the short delay when the reference was already powered or is disabled. Both delays come from a clock-frequency parameter and two delay parameters in nanoseconds.

The host writes the control word with an ordinary 16-clock frame. The same 16 clocks also frame each conversion. The automatic modes use that framing to power the converter up at the start of a frame and down at its end.

Top module: `adcpm_top`

## Requirements
- R1: After reset, `conv_pwr_on`, `ref_pwr_on` and `conv_ready` are low. The control word holds mode 00 with the reference enabled.
- R2: In mode 00, a chip-select falling edge powers the converter up and a chip-select rising edge powers it down.
- R3: In mode 00, a chip-select rising edge in the middle of a frame powers the converter down at once. It does not wait for the frame to finish.
- R4: In modes 10 and 11, the converter stays off after chip-select falls. It powers up on the first serial-clock falling edge of the frame.
- R5: In modes 10 and 11, the converter powers down on the 16th serial-clock rising edge of the frame while chip-select is still low. In mode 00 it stays on at that edge.
- R6: In mode 01, the converter never powers up, whatever happens on chip-select and serial clock.
- R7: `ref_pwr_on` is high exactly when control bit 5 is 0 and either the converter is on or the mode is 11.
- R8: `conv_ready` rises a fixed number of system clocks after `conv_pwr_on` rises. The count is the long delay (CLK_MHZ*FULL_UP_NS/1000) when the reference was off and is enabled. It is the short delay (CLK_MHZ*STBY_UP_NS/1000) when the reference was already on or bit 5 is 1.
- R9: `conv_ready` is low whenever the converter is off.
- R10: The control word is shifted in MSB first on serial-clock rising edges. The mode is taken from bits 9:8 (00 chip-select driven, 01 full power-down, 10 auto-shutdown, 11 auto-standby). The reference-disable flag is bit 5. The word is loaded on the chip-select rising edge.
- R11: A frame with fewer than 16 serial-clock rising edges leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles low, asynchronous |
| sdi | input | 1 | Serial data into the control word |
| conv_pwr_on | output | 1 | Power request for the converter core |
| ref_pwr_on | output | 1 | Power request for the internal reference |
| conv_ready | output | 1 | Converter powered and its power-up delay has expired |

## Verification
The assertions assume that every level on chip-select and serial clock lasts several system clocks, so the synchronizers see each edge exactly once. They also assume that serial data is steady around each serial-clock rising edge for the synchronizer latency, and that chip-select never moves in the same system clock as a serial-clock edge. The stimulus holds each serial-clock phase for four system clocks and sets data four clocks before the rising edge. It moves chip-select only while the serial clock has been low for several clocks. The sweep covers every mode with the reference both on and off, and derives each expected level and delay from the mode and flag values.

// File: rtl/adcpm_pkg.sv
// Package adcpm_pkg
// Shared power-mode encoding for the ADC power-management controller.
// Assumes: the mode field of the control word is two bits wide.
package adcpm_pkg;

    typedef enum logic [1:0] {
        PM_CS_DRIVEN = 2'b00,
        PM_FULL_OFF  = 2'b01,
        PM_AUTO_SHDN = 2'b10,
        PM_AUTO_STBY = 2'b11
    } pm_mode_e;

endpackage

// File: rtl/adcpm_sync.sv
// Module adcpm_sync
// Two-flop synchronizer per bit, followed by one history flop.
// Outputs the synchronized level and the level one clock earlier.
// Edge detection is done by the consumer from the pair.
// Assumes: each input level lasts at least three system clocks.
module adcpm_sync #(
    parameter int               W       = 3,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q, hist_q;

        // Purpose: move one asynchronous bit into clk domain and keep a one-clock history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
                hist_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign lvl_o[i] = sync_q;
        assign prv_o[i] = hist_q;
    end

endmodule

// File: rtl/adcpm_frame.sv
// Module adcpm_frame
// Counts serial-clock rising edges inside a chip-select frame and
// shifts the control word in, MSB first.
// Loads mode and reference-disable on the chip-select rising edge, and
// only when a whole frame arrived. Flags the last rising edge of the frame.
// Assumes: edge pulses are one clock wide and come from synchronized lines.
module adcpm_frame
    import adcpm_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int MODE_LSB   = 8,
    parameter int REFDIS_BIT = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_low_i,
    input  logic     cs_fall_i,
    input  logic     cs_rise_i,
    input  logic     sclk_rise_i,
    input  logic     sdi_bit_i,
    output pm_mode_e mode_o,
    output logic     ref_dis_o,
    output logic     last_edge_o
);

    localparam int CW = $clog2(FRAME_BITS + 1);

    logic [CW-1:0]         cnt_q;
    logic [FRAME_BITS-1:0] shift_q;
    pm_mode_e              mode_q;
    logic                  ref_dis_q;
    logic                  frame_full;
    logic                  take_bit;

    assign frame_full  = (cnt_q == CW'(FRAME_BITS));
    assign take_bit    = sclk_rise_i && cs_low_i && !frame_full;
    assign last_edge_o = take_bit && (cnt_q == CW'(FRAME_BITS - 1));

    // Purpose: count edges in the frame and shift data bits in, stopping at a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (cs_fall_i) begin
            cnt_q   <= '0;
        end else if (take_bit) begin
            cnt_q   <= cnt_q + 1'b1;
            shift_q <= {shift_q[FRAME_BITS-2:0], sdi_bit_i};
        end
    end

    // Purpose: commit the control fields when a complete frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= PM_CS_DRIVEN;
            ref_dis_q <= 1'b0;
        end else if (cs_rise_i && frame_full) begin
            mode_q    <= pm_mode_e'(shift_q[MODE_LSB +: 2]);
            ref_dis_q <= shift_q[REFDIS_BIT];
        end
    end

    assign mode_o    = mode_q;
    assign ref_dis_o = ref_dis_q;

    // R11
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_rise_i && frame_full) |=> ($stable(mode_q) && $stable(ref_dis_q)));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FRAME_BITS));

endmodule

// File: rtl/adcpm_power.sv
// Module adcpm_power
// Power state machine: converter power, reference power and the ready timer.
// Chooses the long or the short delay from the state of the reference at power-up.
// Assumes: edge pulses are single-cycle and a new mode takes effect the clock after loading.
module adcpm_power
    import adcpm_pkg::*;
#(
    parameter int LONG_CYC  = 1250,
    parameter int SHORT_CYC = 250
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_e mode_i,
    input  logic     ref_dis_i,
    input  logic     cs_low_i,
    input  logic     cs_fall_i,
    input  logic     cs_rise_i,
    input  logic     sclk_fall_i,
    input  logic     last_edge_i,
    output logic     conv_on_o,
    output logic     ref_on_o,
    output logic     ready_o
);

    localparam int TW = $clog2(LONG_CYC + 1);

    logic          conv_q;
    logic          armed_q;
    logic [TW-1:0] tmr_q;
    logic          auto_mode;
    logic          up_req;
    logic          dn_req;
    logic          ref_warm;

    assign auto_mode = (mode_i == PM_AUTO_SHDN) || (mode_i == PM_AUTO_STBY);
    assign up_req    = ((mode_i == PM_CS_DRIVEN) && cs_fall_i)
                    || (auto_mode && armed_q && sclk_fall_i && cs_low_i);
    assign dn_req    = cs_rise_i || (auto_mode && last_edge_i) || (mode_i == PM_FULL_OFF);
    assign ref_warm  = ref_on_o || ref_dis_i;

    // Purpose: arm the automatic power-up for the first serial-clock fall of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                        armed_q <= 1'b0;
        else if (cs_fall_i)                armed_q <= 1'b1;
        else if (sclk_fall_i || cs_rise_i) armed_q <= 1'b0;
    end

    // Purpose: converter power state and power-up delay countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            tmr_q  <= '0;
        end else if (dn_req) begin
            conv_q <= 1'b0;
            tmr_q  <= '0;
        end else if (up_req && !conv_q) begin
            conv_q <= 1'b1;
            tmr_q  <= ref_warm ? TW'(SHORT_CYC) : TW'(LONG_CYC);
        end else if (conv_q && tmr_q != '0) begin
            tmr_q  <= tmr_q - 1'b1;
        end
    end

    assign conv_on_o = conv_q;
    assign ref_on_o  = !ref_dis_i && (conv_q || mode_i == PM_AUTO_STBY);
    assign ready_o   = conv_q && (tmr_q == '0);

    // R2
    cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise_i |=> !conv_q);

    // R5
    auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && last_edge_i) |=> !conv_q);

    // R6
    full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PM_FULL_OFF && $past(mode_i == PM_FULL_OFF)) |-> !conv_q);

    // R8
    delay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_q) |-> (!ready_o && tmr_q >= TW'(SHORT_CYC)));

endmodule

// File: rtl/adcpm_top.sv
// Module adcpm_top
// ADC serial power-management controller.
// Synchronizes the serial lines, decodes the control frame and drives the
// converter/reference power requests and the ready flag.
// Assumes: sclk idles low; every line level lasts several system clocks.
module adcpm_top
    import adcpm_pkg::*;
#(
    parameter int CLK_MHZ    = 250,
    parameter int FULL_UP_NS = 5000,
    parameter int STBY_UP_NS = 1000,
    parameter int FRAME_BITS = 16,
    parameter int MODE_LSB   = 8,
    parameter int REFDIS_BIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic conv_pwr_on,
    output logic ref_pwr_on,
    output logic conv_ready
);

    localparam int LONG_CYC  = CLK_MHZ * FULL_UP_NS / 1000;
    localparam int SHORT_CYC = CLK_MHZ * STBY_UP_NS / 1000;
    localparam int NSYNC     = 3;
    localparam int B_CS      = 0;
    localparam int B_SCLK    = 1;
    localparam int B_SDI     = 2;

    logic [NSYNC-1:0] lvl, prv;
    logic cs_fall, cs_rise, cs_low, sclk_rise, sclk_fall, last_edge;
    pm_mode_e mode;
    logic ref_dis;

    adcpm_sync #(.W(NSYNC), .RST_VAL(3'b001)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sdi, sclk, cs_n}),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    assign cs_low    = !lvl[B_CS];
    assign cs_fall   = prv[B_CS] && !lvl[B_CS];
    assign cs_rise   = !prv[B_CS] && lvl[B_CS];
    assign sclk_rise = !prv[B_SCLK] && lvl[B_SCLK];
    assign sclk_fall = prv[B_SCLK] && !lvl[B_SCLK];

    adcpm_frame #(
        .FRAME_BITS (FRAME_BITS),
        .MODE_LSB   (MODE_LSB),
        .REFDIS_BIT (REFDIS_BIT)
    ) i_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low_i    (cs_low),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sclk_rise_i (sclk_rise),
        .sdi_bit_i   (prv[B_SDI]),
        .mode_o      (mode),
        .ref_dis_o   (ref_dis),
        .last_edge_o (last_edge)
    );

    adcpm_power #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) i_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .ref_dis_i   (ref_dis),
        .cs_low_i    (cs_low),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sclk_fall_i (sclk_fall),
        .last_edge_i (last_edge),
        .conv_on_o   (conv_pwr_on),
        .ref_on_o    (ref_pwr_on),
        .ready_o     (conv_ready)
    );

    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_pwr_on |-> !conv_ready);

endmodule

// File: tb/test_adcpm_top.sv
// Bench for adcpm_top: sweeps every mode with the reference enabled and
// disabled, plus the cold start, the abort and the short-frame cases.
module test_adcpm_top;

    localparam int LONG  = 250 * 5000 / 1000;
    localparam int SHORT = 250 * 1000 / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic conv_pwr_on, ref_pwr_on, conv_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t_up = 0;
    int meas = -1;
    logic pc = 1'b0, pr = 1'b0;

    always #2 clk = ~clk;

    adcpm_top i_adcpm_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .conv_pwr_on (conv_pwr_on),
        .ref_pwr_on  (ref_pwr_on),
        .conv_ready  (conv_ready)
    );

    // Measure clocks from converter power-up to ready.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (conv_pwr_on && !pc) t_up = cyc;
        if (conv_ready && !pr) meas = cyc - t_up;
        pc = conv_pwr_on;
        pr = conv_ready;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] cfg(input int m, input int rd);
        return 16'((m & 3) << 8) | 16'((rd & 1) << 5);
    endfunction

    task automatic clk_bit(input logic b);
        sdi = b;
        wait_n(4);
        sclk = 1'b1;
        wait_n(4);
        sclk = 1'b0;
        wait_n(4);
    endtask

    task automatic send_frame(input logic [15:0] w, input int n);
        cs_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < n; i++) clk_bit(w[15 - i]);
        cs_n = 1'b1;
        wait_n(8);
    endtask

    // One 16-clock frame that repeats the current configuration and checks each phase.
    task automatic probe(input int m, input int rd);
        logic [15:0] w;
        int exp_dly;
        w = cfg(m, rd);
        exp_dly = (rd != 0 || m == 3) ? SHORT : LONG;
        chk("R7 idle ref", int'(ref_pwr_on), int'(rd == 0 && m == 3));
        meas = -1;
        cs_n = 1'b0;
        wait_n(8);
        chk("R2/R4/R6 after cs fall", int'(conv_pwr_on), int'(m == 0));
        if (m == 0) begin
            wait_n(LONG + 40);
            chk("R8 delay mode 00", meas, exp_dly);
            chk("R7 ref while on", int'(ref_pwr_on), int'(rd == 0));
        end
        clk_bit(w[15]);
        if (m != 0) begin
            chk("R4/R6 after first sclk fall", int'(conv_pwr_on), int'(m != 1));
            if (m >= 2) begin
                wait_n(LONG + 40);
                chk("R8 delay auto", meas, exp_dly);
                chk("R7 ref while on", int'(ref_pwr_on), int'(rd == 0));
            end
        end
        for (int i = 14; i >= 1; i--) clk_bit(w[i]);
        sdi = w[0];
        wait_n(4);
        sclk = 1'b1;
        wait_n(8);
        chk("R5 at 16th sclk rise", int'(conv_pwr_on), int'(m == 0));
        chk("R9 ready at 16th rise", int'(conv_ready), int'(m == 0));
        sclk = 1'b0;
        wait_n(4);
        cs_n = 1'b1;
        wait_n(8);
        chk("R2 after cs rise", int'(conv_pwr_on), 0);
        chk("R9 ready after cs rise", int'(conv_ready), 0);
        chk("R7 ref after frame", int'(ref_pwr_on), int'(rd == 0 && m == 3));
    endtask

    initial begin
        rst_n = 1'b0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        chk("R1 conv after reset", int'(conv_pwr_on), 0);
        chk("R1 ref after reset", int'(ref_pwr_on), 0);
        chk("R1 ready after reset", int'(conv_ready), 0);

        // Cold start: default mode, reference enabled, long delay.
        probe(0, 0);

        // R10: every mode and reference setting, written then probed.
        for (int m = 0; m < 4; m++) begin
            for (int rd = 0; rd < 2; rd++) begin
                send_frame(cfg(m, rd), 16);
                probe(m, rd);
            end
        end

        // R3: chip-select rising mid-frame in mode 00.
        send_frame(cfg(0, 0), 16);
        cs_n = 1'b0;
        wait_n(8);
        chk("R3 on before abort", int'(conv_pwr_on), 1);
        for (int i = 0; i < 5; i++) clk_bit(1'b0);
        cs_n = 1'b1;
        wait_n(5);
        chk("R3 off after abort", int'(conv_pwr_on), 0);
        chk("R3 ready after abort", int'(conv_ready), 0);

        // R11: short frames leave the word unchanged.
        send_frame(cfg(1, 0), 16);
        send_frame(cfg(0, 0), 12);
        cs_n = 1'b0;
        wait_n(10);
        chk("R11 mode kept after short frame", int'(conv_pwr_on), 0);
        cs_n = 1'b1;
        wait_n(8);
        send_frame(cfg(3, 0), 16);
        send_frame(cfg(3, 1), 15);
        chk("R11 ref flag kept after short frame", int'(ref_pwr_on), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule